// File: doc/BRIEF.md
# Local Configuration Access Port

This block gives the local processor direct access to the controller's own configuration registers through a three-word register window. No bus cycle is involved. Software first writes a control word into the address register. That word carries the dword-aligned configuration offset, a direction flag and four active-low lane enables. Software then reads the result register, or writes the data register, to carry out the access.

A write takes effect only when the data register is written while the direction flag is set. Only the enabled byte lanes change. A read returns the whole dword, and software picks out the bytes it needs. The configuration file behind the port holds the following:

- a command word;
- a status word whose received-master-abort flag is set by an event input and cleared by writing one;
- six base address registers, five of them memory space and the last one I/O space;
- a timeout word whose two low bytes drive the retry and ready limits.

Top module: `lcfg_port`

## Requirements
- R1: The address register sits at port offset 0x10. Its layout is: configuration offset in bits [7:2], write flag at bit 16, active-low byte enables in bits [23:20]. Reading port offset 0x10 returns the last word written there.
- R2: A read strobe at port offset 0x18 while the write flag is 0 loads the full configuration dword at the selected offset into the read-data output. The output is valid on the clock edge after the strobe.
- R3: A read strobe at port offset 0x18 while the write flag is 1 returns 0.
- R4: A write at port offset 0x14 while the write flag is 1 commits the data to the selected configuration dword. With the write flag at 0 it changes nothing.
- R5: A committed write updates only byte lane k (bits [8k+7:8k]) for which enable bit 20+k is 0. All other lanes keep their value.
- R6: Configuration offset 0x40 is a 32-bit read/write timeout word. The ready limit output is bits [7:0] and the retry limit output is bits [15:8], so 0x000080FF gives a retry limit of 0x80 and a ready limit of 0xFF.
- R7: Configuration offset 0x04 holds the command word in bits [15:0], which is driven on the command output, and the status word in bits [31:16].
- R8: Status bit 29 of offset 0x04 (received master abort) is set by a pulse on the abort input. It is cleared by a committed write with bit 29 at 1 and lane 3 enabled. Writing 0, or leaving lane 3 disabled, keeps it. If a set and a clear fall in the same cycle, the set wins.
- R9: Base address registers sit at offsets 0x10 to 0x24. Registers 0 to 4 are memory space: bits below 2^24 read 0 and bit 0 reads 0. Register 5 (offset 0x24) is I/O space: bits [7:1] read 0 and bit 0 reads 1.
- R10: Configuration offsets that are not implemented (for example 0x08) read 0, and writes to them have no effect.
- R11: Port offsets other than 0x10 and 0x18 read 0.
- R12: After reset, every configuration register reads 0, except that base address register 5 reads 0x00000001. The command, retry-limit and ready-limit outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Port write strobe |
| bus_rd_i | input | 1 | Port read strobe |
| bus_addr_i | input | 8 | Port byte offset |
| bus_wdata_i | input | 32 | Port write data |
| bus_rdata_o | output | 32 | Registered port read data |
| mabort_i | input | 1 | Received-master-abort event pulse |
| cmd_o | output | 16 | Command word |
| retry_lim_o | output | 8 | Retry timeout limit |
| ready_lim_o | output | 8 | Ready timeout limit |

## Verification
The master-abort flag can be set by its event input and cleared by a software write to the status dword in the same clock edge. The bench provokes this by raising the abort pulse in the very cycle it commits a write-one-to-clear of bit 29. It then reads the status dword and expects the flag still set, since setting has priority. A second, separate clearing write must then drop the flag while the command bits in the same dword stay unchanged.

// File: rtl/lcfg_pkg.sv
package lcfg_pkg;
  // port (processor-side) byte offsets
  localparam int unsigned PORT_ADDR_OFF  = 32'h10;
  localparam int unsigned PORT_WDATA_OFF = 32'h14;
  localparam int unsigned PORT_RDATA_OFF = 32'h18;

  // control word fields
  localparam int unsigned WFLAG_BIT = 16;
  localparam int unsigned BEN_LSB   = 20;

  // configuration dword indices (offset / 4)
  localparam int unsigned IDX_CMDSTS = 1;
  localparam int unsigned IDX_BAR0   = 4;
  localparam int unsigned NUM_BAR    = 6;
  localparam int unsigned IDX_RTO    = 16;
  localparam int unsigned MABORT_BIT = 29;

  function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  ben_n);
    logic [31:0] m;
    for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{~ben_n[k]}};
    return (old_v & ~m) | (new_v & m);
  endfunction
endpackage

// File: rtl/lcfg_host_if.sv
module lcfg_host_if
  import lcfg_pkg::*;
#(
  parameter int PORT_AW = 8,
  parameter int CFG_AW  = 8,
  localparam int IDX_W  = CFG_AW - 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [PORT_AW-1:0] bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  input  logic [31:0]        cfg_rdata_i,
  output logic [IDX_W-1:0]   cfg_idx_o,
  output logic [3:0]         cfg_ben_o,
  output logic               cfg_we_o,
  output logic               wflag_o
);
  localparam logic [PORT_AW-1:0] A_OFF = PORT_AW'(PORT_ADDR_OFF);
  localparam logic [PORT_AW-1:0] W_OFF = PORT_AW'(PORT_WDATA_OFF);
  localparam logic [PORT_AW-1:0] R_OFF = PORT_AW'(PORT_RDATA_OFF);

  logic [31:0] ctl_q;
  logic [31:0] rdata_q;

  assign wflag_o   = ctl_q[WFLAG_BIT];
  assign cfg_ben_o = ctl_q[BEN_LSB +: 4];
  assign cfg_idx_o = ctl_q[CFG_AW-1:2];
  assign cfg_we_o  = bus_wr_i && (bus_addr_i == W_OFF) && wflag_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (bus_wr_i && bus_addr_i == A_OFF) begin
      ctl_q <= bus_wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd_i) begin
      if (bus_addr_i == A_OFF)      rdata_q <= ctl_q;
      else if (bus_addr_i == R_OFF) rdata_q <= wflag_o ? 32'h0 : cfg_rdata_i;
      else                          rdata_q <= 32'h0;
    end
  end

  assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/lcfg_bar.sv
module lcfg_bar
  import lcfg_pkg::*;
#(
  parameter bit IS_IO     = 1'b0,
  parameter int SIZE_LOG2 = 24
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        we_i,
  input  logic [3:0]  ben_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] val_o
);
  localparam logic [31:0] KEEP = ~((32'h1 << SIZE_LOG2) - 32'h1);

  logic [31:0] base_q;

  always_ff @(posedge clk) begin
    if (rst)       base_q <= '0;
    else if (we_i) base_q <= lane_merge(base_q, wdata_i, ben_i) & KEEP;
  end

  assign val_o = (base_q & KEEP) | {31'h0, IS_IO};
endmodule

// File: rtl/lcfg_regfile.sv
module lcfg_regfile
  import lcfg_pkg::*;
#(
  parameter int CFG_AW       = 8,
  parameter int BAR_MEM_LOG2 = 24,
  parameter int BAR_IO_LOG2  = 8,
  localparam int IDX_W       = CFG_AW - 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [3:0]       ben_i,
  input  logic             we_i,
  input  logic [31:0]      wdata_i,
  input  logic             mabort_i,
  output logic [31:0]      rdata_o,
  output logic [15:0]      cmd_o,
  output logic [31:0]      rto_o,
  output logic             ma_o
);
  localparam logic [IDX_W-1:0] I_CS  = IDX_W'(IDX_CMDSTS);
  localparam logic [IDX_W-1:0] I_RTO = IDX_W'(IDX_RTO);

  logic [15:0] cmd_q;
  logic        ma_q;
  logic [31:0] rto_q;
  logic [31:0] bar_val [NUM_BAR];
  logic        ma_clr;

  assign ma_clr = we_i && idx_i == I_CS && !ben_i[3] && wdata_i[MABORT_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      ma_q  <= 1'b0;
      rto_q <= '0;
    end else begin
      if (we_i && idx_i == I_CS)
        cmd_q <= lane_merge({16'h0, cmd_q}, wdata_i, ben_i)[15:0];
      if (we_i && idx_i == I_RTO)
        rto_q <= lane_merge(rto_q, wdata_i, ben_i);
      // set has priority over a simultaneous clear
      ma_q <= (ma_q && !ma_clr) || mabort_i;
    end
  end

  for (genvar b = 0; b < NUM_BAR; b++) begin : g_bar
    localparam bit IO = (b == NUM_BAR - 1);
    lcfg_bar #(
      .IS_IO    (IO),
      .SIZE_LOG2(IO ? BAR_IO_LOG2 : BAR_MEM_LOG2)
    ) u_bar (
      .clk    (clk),
      .rst    (rst),
      .we_i   (we_i && idx_i == IDX_W'(IDX_BAR0 + b)),
      .ben_i  (ben_i),
      .wdata_i(wdata_i),
      .val_o  (bar_val[b])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (idx_i == I_CS) rdata_o = {2'b00, ma_q, 13'h0, cmd_q};
    else if (idx_i == I_RTO) rdata_o = rto_q;
    for (int b = 0; b < NUM_BAR; b++)
      if (idx_i == IDX_W'(IDX_BAR0 + b)) rdata_o = bar_val[b];
  end

  assign cmd_o = cmd_q;
  assign rto_o = rto_q;
  assign ma_o  = ma_q;
endmodule

// File: rtl/lcfg_port.sv
module lcfg_port
  import lcfg_pkg::*;
#(
  parameter int PORT_AW      = 8,
  parameter int CFG_AW       = 8,
  parameter int BAR_MEM_LOG2 = 24,
  parameter int BAR_IO_LOG2  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [PORT_AW-1:0] bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  input  logic               mabort_i,
  output logic [15:0]        cmd_o,
  output logic [7:0]         retry_lim_o,
  output logic [7:0]         ready_lim_o
);
  localparam int IDX_W = CFG_AW - 2;

  logic [IDX_W-1:0] cfg_idx;
  logic [3:0]       cfg_ben;
  logic             cfg_we;
  logic             wflag;
  logic [31:0]      cfg_rdata;
  logic [31:0]      rto;
  logic             ma_sts;

  lcfg_host_if #(.PORT_AW(PORT_AW), .CFG_AW(CFG_AW)) u_if (
    .clk        (clk),
    .rst        (rst),
    .bus_wr_i   (bus_wr_i),
    .bus_rd_i   (bus_rd_i),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o),
    .cfg_rdata_i(cfg_rdata),
    .cfg_idx_o  (cfg_idx),
    .cfg_ben_o  (cfg_ben),
    .cfg_we_o   (cfg_we),
    .wflag_o    (wflag)
  );

  lcfg_regfile #(
    .CFG_AW(CFG_AW), .BAR_MEM_LOG2(BAR_MEM_LOG2), .BAR_IO_LOG2(BAR_IO_LOG2)
  ) u_rf (
    .clk     (clk),
    .rst     (rst),
    .idx_i   (cfg_idx),
    .ben_i   (cfg_ben),
    .we_i    (cfg_we),
    .wdata_i (bus_wdata_i),
    .mabort_i(mabort_i),
    .rdata_o (cfg_rdata),
    .cmd_o   (cmd_o),
    .rto_o   (rto),
    .ma_o    (ma_sts)
  );

  assign ready_lim_o = rto[7:0];
  assign retry_lim_o = rto[15:8];
endmodule

// File: rtl/lcfg_port_chk.sv
module lcfg_port_chk
  import lcfg_pkg::*;
#(
  parameter int PORT_AW = 8,
  parameter int IDX_W   = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_rd_i,
  input logic [PORT_AW-1:0] bus_addr_i,
  input logic [31:0]        bus_rdata_o,
  input logic               mabort_i,
  input logic [15:0]        cmd_o,
  input logic [7:0]         retry_lim_o,
  input logic [7:0]         ready_lim_o,
  input logic               cfg_we,
  input logic               wflag,
  input logic [IDX_W-1:0]   cfg_idx,
  input logic               ma_sts
);
  // R8
  abort_set_chk: assert property (@(posedge clk) disable iff (rst)
    mabort_i |=> ma_sts);

  // R6
  limits_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> ($stable(retry_lim_o) && $stable(ready_lim_o)));

  // R7
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(cmd_o));

  // R9
  io_bar_bit0_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_i && bus_addr_i == PORT_AW'(PORT_RDATA_OFF) && !wflag &&
     cfg_idx == IDX_W'(IDX_BAR0 + NUM_BAR - 1)) |=> bus_rdata_o[0]);

  // R3
  wflag_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_i && bus_addr_i == PORT_AW'(PORT_RDATA_OFF) && wflag)
      |=> bus_rdata_o == 32'h0);

  // R11
  other_off_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_i && bus_addr_i != PORT_AW'(PORT_ADDR_OFF) &&
     bus_addr_i != PORT_AW'(PORT_RDATA_OFF)) |=> bus_rdata_o == 32'h0);
endmodule

bind lcfg_port lcfg_port_chk #(.PORT_AW(PORT_AW), .IDX_W(CFG_AW - 2)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_rd_i   (bus_rd_i),
  .bus_addr_i (bus_addr_i),
  .bus_rdata_o(bus_rdata_o),
  .mabort_i   (mabort_i),
  .cmd_o      (cmd_o),
  .retry_lim_o(retry_lim_o),
  .ready_lim_o(ready_lim_o),
  .cfg_we     (cfg_we),
  .wflag      (wflag),
  .cfg_idx    (cfg_idx),
  .ma_sts     (ma_sts)
);

// File: tb/sim_lcfg_port.sv
module sim_lcfg_port;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mabort = 1'b0;
  logic [15:0] cmd;
  logic [7:0]  retry_lim;
  logic [7:0]  ready_lim;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_pend = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcfg_port u0 (
    .clk(clk), .rst(rst), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .mabort_i(mabort), .cmd_o(cmd), .retry_lim_o(retry_lim),
    .ready_lim_o(ready_lim)
  );

  function automatic logic [31:0] mk(input logic [7:0] off, input logic wr,
                                     input logic [3:0] ben);
    return {8'h00, ben, 3'b000, wr, 8'h00, off};
  endfunction

  // monitor: compares registered read data one edge after each strobe
  always @(posedge clk) rd_pend <= bus_rd;
  always @(negedge clk) begin
    if (rd_pend) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_tests++;
      if (bus_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: read got %08h expected %08h", t, bus_rdata, e);
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp_v, input string t);
    n_tests++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", t, act, exp_v);
    end
  endtask

  task automatic pwr(input logic [7:0] off, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = off; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic prd(input logic [7:0] off, input logic [31:0] exp_v, input string t);
    exp_q.push_back(exp_v);
    tag_q.push_back(t);
    bus_rd = 1'b1; bus_addr = off;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic cwr(input logic [7:0] off, input logic [3:0] ben, input logic [31:0] d);
    pwr(8'h10, mk(off, 1'b1, ben));
    pwr(8'h14, d);
  endtask

  task automatic crd(input logic [7:0] off, input logic [31:0] exp_v, input string t);
    pwr(8'h10, mk(off, 1'b0, 4'h0));
    prd(8'h18, exp_v, t);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R12 reset state
    chk({16'h0, cmd}, 32'h0, "R12 cmd after reset");
    chk({16'h0, retry_lim, ready_lim}, 32'h0, "R12 limits after reset");
    crd(8'h04, 32'h0, "R12 cmd/status reset");
    crd(8'h10, 32'h0, "R12 bar0 reset");
    crd(8'h24, 32'h1, "R12 bar5 reset");
    crd(8'h40, 32'h0, "R12 timeout reset");

    // R1 address register readback
    pwr(8'h10, 32'h00F1_0040);
    prd(8'h10, 32'h00F1_0040, "R1 control word readback");

    // R6 timeout word and limits
    cwr(8'h40, 4'h0, 32'h0000_80FF);
    chk({24'h0, retry_lim}, 32'h80, "R6 retry limit");
    chk({24'h0, ready_lim}, 32'hFF, "R6 ready limit");
    crd(8'h40, 32'h0000_80FF, "R2 R6 timeout full dword");

    // R5 single-lane update of timeout
    cwr(8'h40, 4'b1110, 32'h1122_3344);
    crd(8'h40, 32'h0000_8044, "R5 lane0 only");

    // R7 command word
    cwr(8'h04, 4'h0, 32'h1234_5678);
    chk({16'h0, cmd}, 32'h5678, "R7 cmd output");
    crd(8'h04, 32'h0000_5678, "R7 cmd dword");
    cwr(8'h04, 4'b1101, 32'h0000_AB00);
    chk({16'h0, cmd}, 32'hAB78, "R5 cmd lane1 only");

    // R4 write flag clear: data write has no effect
    pwr(8'h10, mk(8'h04, 1'b0, 4'h0));
    pwr(8'h14, 32'h0000_FFFF);
    chk({16'h0, cmd}, 32'hAB78, "R4 no commit without flag");

    // R3 read with write flag set
    pwr(8'h10, mk(8'h04, 1'b1, 4'h0));
    prd(8'h18, 32'h0, "R3 read with flag set");

    // R8 master abort set / clear
    @(negedge clk);
    mabort = 1'b1; @(negedge clk); mabort = 1'b0;
    crd(8'h04, 32'h2000_AB78, "R8 abort flag set");
    cwr(8'h04, 4'b0111, 32'h0000_0000);
    crd(8'h04, 32'h2000_AB78, "R8 write zero keeps flag");
    cwr(8'h04, 4'hF, 32'h2000_0000);
    crd(8'h04, 32'h2000_AB78, "R8 lane3 disabled keeps flag");
    // set and clear in the same cycle: set wins
    pwr(8'h10, mk(8'h04, 1'b1, 4'b0111));
    bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h2000_0000; mabort = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; mabort = 1'b0;
    crd(8'h04, 32'h2000_AB78, "R8 set wins over clear");
    cwr(8'h04, 4'b0111, 32'h2000_0000);
    crd(8'h04, 32'h0000_AB78, "R8 one clears flag");

    // R9 base address alignment
    cwr(8'h10, 4'h0, 32'hFFFF_FFFF);
    crd(8'h10, 32'hFF00_0000, "R9 bar0 alignment");
    cwr(8'h20, 4'h0, 32'h1234_5679);
    crd(8'h20, 32'h1200_0000, "R9 bar4 alignment");
    cwr(8'h24, 4'h0, 32'hFFFF_FC01);
    crd(8'h24, 32'hFFFF_FC01, "R9 bar5 io value");
    cwr(8'h24, 4'h0, 32'h0000_00FE);
    crd(8'h24, 32'h0000_0001, "R9 bar5 low bits");
    crd(8'h14, 32'h0, "R9 bar1 untouched");

    // R10 unimplemented offsets
    cwr(8'h08, 4'h0, 32'hDEAD_BEEF);
    crd(8'h08, 32'h0, "R10 unimplemented read zero");
    crd(8'h40, 32'h0000_8044, "R10 timeout unaffected");
    chk({16'h0, cmd}, 32'hAB78, "R10 cmd unaffected");

    // R11 other port offsets
    prd(8'h14, 32'h0, "R11 port 0x14 reads zero");
    prd(8'h1C, 32'h0, "R11 port 0x1C reads zero");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule